// File: doc/BRIEF.md
# I2C Byte Ring Shifter

This block is the serial data path of an I2C controller. A CPU-visible byte register, a one-bit acknowledge flag and an open-drain output latch form a nine-bit ring. Bus data is sampled into the ring on every rising SCL edge, including the bits the block is sending itself. At the end of each transfer the byte register therefore holds the byte that actually appeared on the bus. This stays true when another master has overridden the transmission.

The controller around it handles START/STOP, clock generation and the master/slave sequencing. It pulses `xfer_start_i` when a byte transfer begins and selects the direction with `tx_mode_i`. In transmit mode the CPU writes a byte, and its most significant bit reaches the line at once. Each later bit is moved out on a falling SCL edge. In receive mode the block keeps SDA released for the data bits. It then drives the acknowledge bit chosen by `ack_en_i` during the ninth clock. A one-cycle `byte_done_o` pulse marks the end of every nine-clock transfer.

Top module: `i2c_ring_shifter`

## Requirements
- R1: After reset, SDA is released (`sda_drive_low_o`=0), `data_o`=0x00, `ack_flag_o`=1, `arb_lost_o`=0 and `byte_done_o`=0.
- R2: A CPU write loads `data_o` on the next clock. With `tx_mode_i`=1 (transmit) it also sets `sda_drive_low_o` to the inverse of `wr_data_i[7]`. With `tx_mode_i`=0 (receive) it releases SDA.
- R3: In transmit mode the byte leaves MSB first. The line value changes only after a falling SCL edge (or a write), never while SCL is high.
- R4: On each rising SCL edge the SDA value enters the acknowledge flag and the previous flag value enters bit 0 of the byte, which shifts toward bit 7. After nine rising edges `data_o` holds the first eight bus bits (first bit in bit 7) and `ack_flag_o` holds the ninth.
- R5: `ack_flag_o` is 0 when the ninth bus bit was low (acknowledged) and 1 when it was high (not acknowledged).
- R6: In transmit mode SDA is released for the ninth clock so the receiver can answer.
- R7: In transmit mode, if SDA is released during a data bit but a 0 is sampled on the rising edge, `arb_lost_o` sets and stays set. SDA is then released for the rest of the byte while bus bits keep shifting in.
- R8: `arb_lost_o` clears on a CPU write or on `xfer_start_i`.
- R9: In receive mode SDA is released for bits 1 to 8. For the ninth clock it is driven low when `ack_en_i`=1 and released when `ack_en_i`=0.
- R10: After the falling edge that ends the ninth clock, SDA is released.
- R11: `byte_done_o` is a single-cycle pulse, issued once per byte after the falling edge that ends the ninth clock.
- R12: A CPU write or an `xfer_start_i` pulse restarts the bit count, so a partial byte before it produces no `byte_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| wr_en_i | input | 1 | CPU write strobe for the byte register |
| wr_data_i | input | 8 | CPU write data |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| ack_en_i | input | 1 | Receive: 1 = drive ACK on ninth bit, 0 = NACK |
| xfer_start_i | input | 1 | Transfer-start pulse, restarts bit count and clears arbitration flag |
| sda_drive_low_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| data_o | output | 8 | Byte register contents |
| ack_flag_o | output | 1 | Ninth-bit flag (0 = ACK) |
| byte_done_o | output | 1 | One-cycle end-of-byte pulse |
| arb_lost_o | output | 1 | Sticky arbitration-lost flag |

## Verification
A ring that shifts in the wrong direction, or that skips the acknowledge stage, shows up in `data_o` at the end of the very next byte. A wrong bit count shows up as a missing or early `byte_done_o`, or as SDA being driven during the wrong clock. An output latch that misses a falling edge puts the wrong bit on the line before the following rising SCL edge. The bench sees this at once, because it records SDA on every bit. A broken arbitration check leaves the block pulling SDA low while another master owns the line, and the next rising edge then samples a corrupted bus byte.

// File: rtl/i2c_ring_pkg.sv
package i2c_ring_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    MODE_RX = 1'b0,
    MODE_TX = 1'b1
  } xfer_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } scl_edge_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= {STAGES{RESET_VAL}};
    else         sync_q <= {sync_q[STAGES-2:0], line_i};
  end

  assign line_o = sync_q[STAGES-1];
endmodule

// File: rtl/i2c_bit_counter.sv
module i2c_bit_counter #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LAST  = BYTE_W + 1,
  localparam int unsigned CNT_W = $clog2(LAST + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     restart_i,
  input  i2c_ring_pkg::scl_edge_t  edge_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             end_fall;

  assign end_fall = edge_i.fall && (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= end_fall && !restart_i;
      if (restart_i)                                cnt_q <= '0;
      else if (edge_i.rise && cnt_q < CNT_W'(LAST)) cnt_q <= cnt_q + 1'b1;
      else if (end_fall)                            cnt_q <= '0;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/i2c_ring_datapath.sv
module i2c_ring_datapath #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned LAST  = BYTE_W + 1,
  localparam int unsigned CNT_W = $clog2(LAST + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  i2c_ring_pkg::scl_edge_t  edge_i,
  input  logic                     sda_i,
  input  i2c_ring_pkg::xfer_mode_e mode_i,
  input  logic                     ack_en_i,
  input  logic                     wr_en_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic                     xfer_start_i,
  input  logic [CNT_W-1:0]         cnt_i,
  output logic [BYTE_W-1:0]        byte_o,
  output logic                     ack_o,
  output logic                     line_o,
  output logic                     arb_lost_o
);
  import i2c_ring_pkg::*;

  logic [BYTE_W-1:0] byte_q;
  logic              ack_q;
  logic              line_q;
  logic              arb_q;
  logic              is_tx;
  logic              data_bit;
  logic              arb_hit;
  logic              line_nxt;

  assign is_tx    = (mode_i == MODE_TX);
  assign data_bit = (cnt_i < CNT_W'(BYTE_W));
  assign arb_hit  = is_tx && data_bit && line_q && !sda_i;

  // next latch value on a falling SCL edge
  always_comb begin
    line_nxt = line_q;
    if (cnt_i >= CNT_W'(1) && cnt_i < CNT_W'(BYTE_W))
      line_nxt = (is_tx && !arb_q) ? byte_q[BYTE_W-1] : 1'b1;
    else if (cnt_i == CNT_W'(BYTE_W))
      line_nxt = (is_tx || arb_q) ? 1'b1 : !ack_en_i;
    else if (cnt_i == CNT_W'(LAST))
      line_nxt = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q <= '0;
      ack_q  <= 1'b1;
      line_q <= 1'b1;
      arb_q  <= 1'b0;
    end else if (wr_en_i) begin
      byte_q <= wr_data_i;
      line_q <= is_tx ? wr_data_i[BYTE_W-1] : 1'b1;
      arb_q  <= 1'b0;
    end else begin
      if (edge_i.rise) begin
        {byte_q, ack_q} <= {byte_q[BYTE_W-2:0], ack_q, sda_i};
      end
      if (xfer_start_i)                arb_q <= 1'b0;
      else if (edge_i.rise && arb_hit) arb_q <= 1'b1;
      if (edge_i.fall) line_q <= line_nxt;
    end
  end

  assign byte_o     = byte_q;
  assign ack_o      = ack_q;
  assign line_o     = line_q;
  assign arb_lost_o = arb_q;
endmodule

// File: rtl/i2c_ring_shifter.sv
module i2c_ring_shifter #(
  parameter int unsigned BYTE_W      = i2c_ring_pkg::BYTE_W,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CNT_W      = $clog2(BYTE_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              tx_mode_i,
  input  logic              ack_en_i,
  input  logic              xfer_start_i,
  output logic              sda_drive_low_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              ack_flag_o,
  output logic              byte_done_o,
  output logic              arb_lost_o
);
  import i2c_ring_pkg::*;

  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] line_raw;
  logic [N_LINES-1:0] line_sync;
  logic               scl_sync;
  logic               sda_sync;
  logic               scl_prev_q;
  scl_edge_t          scl_edge;
  logic [CNT_W-1:0]   bit_cnt;
  logic               line_q;
  xfer_mode_e         mode;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
    ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(line_raw[g]),
      .line_o(line_sync[g])
    );
  end

  assign scl_sync = line_sync[0];
  assign sda_sync = line_sync[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) scl_prev_q <= 1'b1;
    else         scl_prev_q <= scl_sync;
  end

  assign scl_edge.rise = scl_sync && !scl_prev_q;
  assign scl_edge.fall = !scl_sync && scl_prev_q;
  assign mode          = tx_mode_i ? MODE_TX : MODE_RX;

  i2c_bit_counter #(
    .BYTE_W(BYTE_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(wr_en_i || xfer_start_i),
    .edge_i   (scl_edge),
    .cnt_o    (bit_cnt),
    .done_o   (byte_done_o)
  );

  i2c_ring_datapath #(
    .BYTE_W(BYTE_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (scl_edge),
    .sda_i       (sda_sync),
    .mode_i      (mode),
    .ack_en_i    (ack_en_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .xfer_start_i(xfer_start_i),
    .cnt_i       (bit_cnt),
    .byte_o      (data_o),
    .ack_o       (ack_flag_o),
    .line_o      (line_q),
    .arb_lost_o  (arb_lost_o)
  );

  assign sda_drive_low_o = !line_q;
endmodule

// File: rtl/i2c_ring_shifter_chk.sv
module i2c_ring_shifter_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              scl_s_i,
  input logic              wr_en_i,
  input logic [BYTE_W-1:0] wr_data_i,
  input logic              tx_mode_i,
  input logic              xfer_start_i,
  input logic              sda_drive_low_o,
  input logic              byte_done_o,
  input logic              arb_lost_o
);
  assert_write_first_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(tx_mode_i)) |-> (sda_drive_low_o == !$past(wr_data_i[BYTE_W-1])));

  assert_line_moves_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_drive_low_o) && !$past(wr_en_i)) |-> !scl_s_i);

  assert_arb_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_lost_o && !wr_en_i && !xfer_start_i) |=> arb_lost_o);

  assert_arb_releases_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_lost_o |-> !sda_drive_low_o);

  assert_arb_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i || xfer_start_i) |=> !arb_lost_o);

  assert_done_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_done_o |=> !byte_done_o);
endmodule

bind i2c_ring_shifter i2c_ring_shifter_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .scl_s_i        (scl_sync),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .tx_mode_i      (tx_mode_i),
  .xfer_start_i   (xfer_start_i),
  .sda_drive_low_o(sda_drive_low_o),
  .byte_done_o    (byte_done_o),
  .arb_lost_o     (arb_lost_o)
);

// File: tb/i2c_ring_shifter_tb.sv
`timescale 1ns/1ps
module i2c_ring_shifter_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b0;
  logic       ext_sda = 1'b1;
  logic       sda;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       tx_mode = 1'b1;
  logic       ack_en = 1'b1;
  logic       xfer_start = 1'b0;
  logic       drive_low;
  logic [7:0] data;
  logic       ack_flag;
  logic       byte_done;
  logic       arb_lost;

  int total = 0;
  int bad = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  assign sda = ext_sda & ~drive_low;

  i2c_ring_shifter u_dut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .scl_i          (scl),
    .sda_i          (sda),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .tx_mode_i      (tx_mode),
    .ack_en_i       (ack_en),
    .xfer_start_i   (xfer_start),
    .sda_drive_low_o(drive_low),
    .data_o         (data),
    .ack_flag_o     (ack_flag),
    .byte_done_o    (byte_done),
    .arb_lost_o     (arb_lost)
  );

  always @(negedge clk) if (rst_n && byte_done) done_cnt++;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_pulse();
    @(negedge clk);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
  endtask

  // ext[8] is the first bit; drv records drive_low just before each rising edge
  task automatic run_pulses(input logic [8:0] ext, input int n, output logic [8:0] drv);
    drv = '0;
    for (int i = 0; i < n; i++) begin
      ext_sda = ext[8-i];
      wait_clk(5);
      drv[8-i] = drive_low;
      scl = 1'b1;
      wait_clk(3);
      check(drive_low == drv[8-i], "R3", "line moved while SCL high", drive_low, drv[8-i]);
      wait_clk(3);
      scl = 1'b0;
      wait_clk(6);
    end
    ext_sda = 1'b1;
  endtask

  task automatic run_byte(input string req, input logic [8:0] ext, input logic [8:0] exp_drv,
                          input logic [7:0] exp_data, input logic exp_ack, input logic exp_arb);
    logic [8:0] drv;
    int d0;
    d0 = done_cnt;
    run_pulses(ext, 9, drv);
    check(drv == exp_drv, req, "per-bit drive pattern", drv, exp_drv);
    check(data == exp_data, "R4", "byte seen on bus", data, exp_data);
    check(ack_flag == exp_ack, "R5", "ninth-bit flag", ack_flag, exp_ack);
    check(arb_lost == exp_arb, "R7", "arbitration flag", arb_lost, exp_arb);
    check(done_cnt == d0 + 1, "R11", "byte_done cycles", done_cnt - d0, 1);
    check(drive_low == 1'b0, "R10", "released after ninth clock", drive_low, 0);
  endtask

  task automatic t_reset();
    check(drive_low == 1'b0, "R1", "reset drive", drive_low, 0);
    check(data == 8'h00, "R1", "reset data", data, 0);
    check(ack_flag == 1'b1, "R1", "reset ack flag", ack_flag, 1);
    check(arb_lost == 1'b0, "R1", "reset arb", arb_lost, 0);
    check(byte_done == 1'b0, "R1", "reset done", byte_done, 0);
  endtask

  task automatic t_write();
    tx_mode = 1'b1;
    cpu_write(8'h5A);
    check(data == 8'h5A, "R2", "write loads byte", data, 8'h5A);
    check(drive_low == 1'b1, "R2", "bit7=0 on line", drive_low, 1);
    cpu_write(8'hC3);
    check(drive_low == 1'b0, "R2", "bit7=1 releases", drive_low, 0);
    tx_mode = 1'b0;
    cpu_write(8'h11);
    check(drive_low == 1'b0, "R2", "receive write releases", drive_low, 0);
  endtask

  task automatic t_tx_ack();
    tx_mode = 1'b1;
    cpu_write(8'h5A);
    run_byte("R6", 9'b1_1111_1110, {8'hA5, 1'b0}, 8'h5A, 1'b0, 1'b0);
  endtask

  task automatic t_tx_nack();
    tx_mode = 1'b1;
    cpu_write(8'hC3);
    run_byte("R6", 9'h1FF, {8'h3C, 1'b0}, 8'hC3, 1'b1, 1'b0);
  endtask

  task automatic t_arb();
    tx_mode = 1'b1;
    cpu_write(8'hF0);
    run_byte("R7", {8'hB3, 1'b0}, 9'h000, 8'hB3, 1'b0, 1'b1);
    start_pulse();
    check(arb_lost == 1'b0, "R8", "xfer_start clears arb", arb_lost, 0);
    cpu_write(8'hF0);
    run_byte("R7", {8'hB3, 1'b0}, 9'h000, 8'hB3, 1'b0, 1'b1);
    cpu_write(8'h80);
    check(arb_lost == 1'b0, "R8", "write clears arb", arb_lost, 0);
  endtask

  task automatic t_rx();
    tx_mode = 1'b0;
    ack_en = 1'b1;
    start_pulse();
    run_byte("R9", {8'h3C, 1'b1}, {8'h00, 1'b1}, 8'h3C, 1'b0, 1'b0);
    ack_en = 1'b0;
    start_pulse();
    run_byte("R9", {8'h96, 1'b1}, 9'h000, 8'h96, 1'b1, 1'b0);
  endtask

  task automatic t_restart();
    logic [8:0] drv;
    int d0;
    tx_mode = 1'b0;
    ack_en = 1'b1;
    start_pulse();
    d0 = done_cnt;
    run_pulses(9'h1FF, 3, drv);
    start_pulse();
    run_pulses({8'h81, 1'b1}, 9, drv);
    check(done_cnt == d0 + 1, "R12", "done count after restart", done_cnt - d0, 1);
    check(drv == {8'h00, 1'b1}, "R12", "ack on restarted ninth bit", drv, {8'h00, 1'b1});
    check(data == 8'h81, "R12", "data after restart", data, 8'h81);
    tx_mode = 1'b1;
    cpu_write(8'h00);
    d0 = done_cnt;
    run_pulses(9'h1FF, 4, drv);
    cpu_write(8'hFF);
    run_pulses(9'h1FF, 8, drv);
    check(done_cnt == d0, "R12", "write restarts count, no early done", done_cnt - d0, 0);
    run_pulses(9'h1FF, 1, drv);
    check(done_cnt == d0 + 1, "R12", "done after nine from write", done_cnt - d0, 1);
  endtask

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(4);
    t_reset();
    t_write();
    t_tx_ack();
    t_tx_nack();
    t_arb();
    t_rx();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule